// File: doc/BRIEF.md
# Energy Meter Pulse Output Stage

This block converts two streams of energy-quantum strobes into metering pulses. Strobes on the slow stream drive a pair of outputs, F1 and F2, in turn, so that a two-phase stepper counter advances once per quantum. Strobes on the fast stream drive a single calibration output, CF. Pulse high times are measured in ticks of a millisecond time base that the surrounding logic supplies as a one-cycle strobe. When quanta arrive slowly, each pulse lasts a nominal number of ticks. When they arrive quickly, the high time is cut to half of the last measured spacing, so that every pulse still ends before the next one is due.

Each stream holds at most one strobe while its output is busy. If a further strobe arrives while one is already held, it is dropped and a sticky flag is raised. Before a slow-stream pulse may start, the slow-stream outputs must have been low for a minimum number of clock cycles. This keeps a clean gap between the end of one phase and the start of the other.

Top module: `emp_pulse_out`

## Requirements
- R1: While rst_n is low, f1_o, f2_o, cf_o, f_ovf_o and cf_ovf_o are 0, and all timers clear. The first slow-stream pulse after reset appears on f1_o.
- R2: f1_o and f2_o are never high together. Successive slow-stream pulses alternate F1, F2, F1, and so on.
- R3: A slow-stream pulse stays high for exactly F_WIDTH cycles that carry ms_tick_i when it is the first since reset or its measured spacing p is at least 2*F_WIDTH.
- R4: A CF pulse stays high for exactly CF_WIDTH cycles that carry ms_tick_i when it is the first since reset or its measured spacing p is at least 2*CF_WIDTH.
- R5: When p is below twice the nominal width, the pulse stays high for max(1, floor(p/2)) ticked cycles. p is the number of ticked cycles from the first high cycle of the previous pulse of the same stream up to, and not including, the cycle just before the new pulse's first high cycle.
- R6: Before a slow-stream output rises, f1_o and f2_o have both been low for at least F_GAP_CYC consecutive clock cycles.
- R7: A strobe that arrives while its output is busy is held, not lost. It produces its pulse once the output is free.
- R8: A strobe that arrives while another of the same stream is already held, and is not being taken in that cycle, is dropped. It sets that stream's overflow output (f_ovf_o or cf_ovf_o), which stays 1 until reset.
- R9: A strobe that arrives on an idle stream, with the gap of R6 already met, makes its output high in the second clock cycle after the strobe cycle.
- R10: The two streams run independently. Every CF strobe that is not dropped yields exactly one CF pulse, whatever the slow stream is doing, and the slow stream likewise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle millisecond time-base strobe |
| f_evt_i | input | 1 | Slow-stream energy-quantum strobe |
| cf_evt_i | input | 1 | Calibration-stream energy-quantum strobe |
| f1_o | output | 1 | First stepper phase pulse |
| f2_o | output | 1 | Second stepper phase pulse |
| cf_o | output | 1 | Calibration pulse |
| f_ovf_o | output | 1 | Sticky flag: a slow-stream strobe was dropped |
| cf_ovf_o | output | 1 | Sticky flag: a calibration strobe was dropped |

## Verification
The bound checker watches the rules that hold on every cycle: the two stepper phases never overlap and always alternate, the low gap comes before each phase starts, no pulse runs longer than its nominal tick count, and the overflow flags never clear by themselves. The exact high time that follows from each measured spacing, the two-cycle start latency, the delivery of held strobes and the dropping of a third strobe can only be shown by the bench. It sweeps strobe spacings across the range where widths shrink and compares every pulse with the width it computes from the spacing.

// File: rtl/emp_pkg.sv
package emp_pkg;

  typedef enum logic {
    TGT_F1 = 1'b0,
    TGT_F2 = 1'b1
  } ftgt_e;

  function automatic int cnt_bits(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/emp_evt_hold.sv
module emp_evt_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic take_i,
  output logic pend_o,
  output logic ovf_o
);

  logic pend_q, pend_d;
  logic ovf_q, ovf_d;
  logic keep;

  always_comb begin
    keep   = pend_q & ~take_i;
    pend_d = evt_i | keep;
    ovf_d  = ovf_q | (evt_i & keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/emp_pulse_timer.sv
module emp_pulse_timer #(
  parameter int W_NOM   = 120,
  parameter int GAP_CYC = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic pulse_o,
  output logic ready_o
);
  import emp_pkg::*;

  localparam int PMAX = 2 * W_NOM;
  localparam int PW   = cnt_bits(PMAX);
  localparam int WW   = cnt_bits(W_NOM);

  logic          pulse_q, pulse_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [WW-1:0] width_q, width_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] half;
  logic [WW-1:0] width_new;
  logic [WW-1:0] wcnt_inc;

  // width chosen from the spacing measured since the previous start
  always_comb begin
    half = pcnt_q >> 1;
    if (pcnt_q >= PW'(PMAX))
      width_new = WW'(W_NOM);
    else if (half == '0)
      width_new = WW'(1);
    else
      width_new = WW'(half);
  end

  assign wcnt_inc = wcnt_q + WW'(1);

  always_comb begin
    pulse_d = pulse_q;
    wcnt_d  = wcnt_q;
    width_d = width_q;
    pcnt_d  = pcnt_q;
    if (start_i) begin
      pulse_d = 1'b1;
      wcnt_d  = '0;
      width_d = width_new;
      pcnt_d  = '0;
    end else begin
      if (tick_i && (pcnt_q < PW'(PMAX)))
        pcnt_d = pcnt_q + PW'(1);
      if (pulse_q && tick_i) begin
        wcnt_d = wcnt_inc;
        if (wcnt_inc == width_q)
          pulse_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      wcnt_q  <= '0;
      width_q <= WW'(W_NOM);
      pcnt_q  <= PW'(PMAX);
    end else begin
      pulse_q <= pulse_d;
      wcnt_q  <= wcnt_d;
      width_q <= width_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign pulse_o = pulse_q;

  generate
    if (GAP_CYC == 0) begin : g_nogap
      assign ready_o = ~pulse_q;
    end else begin : g_gap
      localparam int GW = cnt_bits(GAP_CYC);
      logic [GW-1:0] low_q, low_d;

      always_comb begin
        if (pulse_q)
          low_d = '0;
        else if (low_q < GW'(GAP_CYC))
          low_d = low_q + GW'(1);
        else
          low_d = low_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          low_q <= GW'(GAP_CYC);
        else
          low_q <= low_d;
      end

      assign ready_o = ~pulse_q & (low_q >= GW'(GAP_CYC));
    end
  endgenerate

endmodule

// File: rtl/emp_pulse_out.sv
module emp_pulse_out #(
  parameter int F_WIDTH   = 120,
  parameter int CF_WIDTH  = 90,
  parameter int F_GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick_i,
  input  logic f_evt_i,
  input  logic cf_evt_i,
  output logic f1_o,
  output logic f2_o,
  output logic cf_o,
  output logic f_ovf_o,
  output logic cf_ovf_o
);
  import emp_pkg::*;

  logic  f_pend, f_ready, f_start, f_pulse;
  logic  cf_pend, cf_ready, cf_start, cf_pulse;
  ftgt_e next_q, next_d;
  ftgt_e cur_q, cur_d;

  emp_evt_hold u_f_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (f_evt_i),
    .take_i (f_start),
    .pend_o (f_pend),
    .ovf_o  (f_ovf_o)
  );

  emp_evt_hold u_cf_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (cf_evt_i),
    .take_i (cf_start),
    .pend_o (cf_pend),
    .ovf_o  (cf_ovf_o)
  );

  assign f_start  = f_pend & f_ready;
  assign cf_start = cf_pend & cf_ready;

  emp_pulse_timer #(.W_NOM(F_WIDTH), .GAP_CYC(F_GAP_CYC)) u_f_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick_i),
    .start_i (f_start),
    .pulse_o (f_pulse),
    .ready_o (f_ready)
  );

  emp_pulse_timer #(.W_NOM(CF_WIDTH), .GAP_CYC(0)) u_cf_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick_i),
    .start_i (cf_start),
    .pulse_o (cf_pulse),
    .ready_o (cf_ready)
  );

  // phase steering: each accepted slow strobe goes to the other output
  always_comb begin
    next_d = next_q;
    cur_d  = cur_q;
    if (f_start) begin
      cur_d  = next_q;
      next_d = (next_q == TGT_F1) ? TGT_F2 : TGT_F1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= TGT_F1;
      cur_q  <= TGT_F1;
    end else begin
      next_q <= next_d;
      cur_q  <= cur_d;
    end
  end

  assign f1_o = f_pulse & (cur_q == TGT_F1);
  assign f2_o = f_pulse & (cur_q == TGT_F2);
  assign cf_o = cf_pulse;

endmodule

// File: rtl/emp_pulse_chk.sv
module emp_pulse_chk #(
  parameter int F_WIDTH   = 120,
  parameter int CF_WIDTH  = 90,
  parameter int F_GAP_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick_i,
  input logic f1_o,
  input logic f2_o,
  input logic cf_o,
  input logic f_ovf_o,
  input logic cf_ovf_o
);
  import emp_pkg::*;

  localparam int GW  = cnt_bits(F_GAP_CYC);
  localparam int FHW = cnt_bits(F_WIDTH) + 1;
  localparam int CHW = cnt_bits(CF_WIDTH) + 1;

  logic           p1, p2, exp_f2;
  logic [GW-1:0]  low_run;
  logic [FHW-1:0] f_hi;
  logic [CHW-1:0] cf_hi;
  logic           f_any;

  assign f_any = f1_o | f2_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1      <= 1'b0;
      p2      <= 1'b0;
      exp_f2  <= 1'b0;
      low_run <= GW'(F_GAP_CYC);
      f_hi    <= '0;
      cf_hi   <= '0;
    end else begin
      p1 <= f1_o;
      p2 <= f2_o;
      if (f1_o && !p1) exp_f2 <= 1'b1;
      else if (f2_o && !p2) exp_f2 <= 1'b0;
      if (f_any) low_run <= '0;
      else if (low_run < GW'(F_GAP_CYC)) low_run <= low_run + GW'(1);
      if (!f_any) f_hi <= '0;
      else if (ms_tick_i) f_hi <= f_hi + FHW'(1);
      if (!cf_o) cf_hi <= '0;
      else if (ms_tick_i) cf_hi <= cf_hi + CHW'(1);
    end
  end

  assert_f_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(f1_o && f2_o));

  assert_f1_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_o && !p1) |-> !exp_f2);

  assert_f2_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_o && !p2) |-> exp_f2);

  assert_low_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((f1_o && !p1) || (f2_o && !p2)) |-> (int'(low_run) >= F_GAP_CYC));

  assert_f_width_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_any |-> (int'(f_hi) <= F_WIDTH));

  assert_cf_width_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cf_o |-> (int'(cf_hi) <= CF_WIDTH));

  assert_f_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    f_ovf_o |=> f_ovf_o);

  assert_cf_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cf_ovf_o |=> cf_ovf_o);

endmodule

bind emp_pulse_out emp_pulse_chk #(
  .F_WIDTH   (F_WIDTH),
  .CF_WIDTH  (CF_WIDTH),
  .F_GAP_CYC (F_GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick_i (ms_tick_i),
  .f1_o      (f1_o),
  .f2_o      (f2_o),
  .cf_o      (cf_o),
  .f_ovf_o   (f_ovf_o),
  .cf_ovf_o  (cf_ovf_o)
);

// File: tb/sim_emp_pulse_out.sv
`timescale 1ns/1ps
module sim_emp_pulse_out;

  localparam int FW  = 6;
  localparam int CW  = 4;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n, ms_tick, f_evt, cf_evt;
  logic f1, f2, cf, f_ovf, cf_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int f_rises = 0, cf_rises = 0;
  int f_sent = 0, cf_sent = 0;

  always #5 clk = ~clk;

  emp_pulse_out #(.F_WIDTH(FW), .CF_WIDTH(CW), .F_GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .f_evt_i(f_evt),
    .cf_evt_i(cf_evt), .f1_o(f1), .f2_o(f2), .cf_o(cf),
    .f_ovf_o(f_ovf), .cf_ovf_o(cf_ovf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_width(input bit first, input int p, input int w);
    int h;
    if (first || p >= 2 * w) return w;
    h = p / 2;
    return (h == 0) ? 1 : h;
  endfunction

  // time base: one ticked cycle in every ten
  initial begin
    int div = 0;
    ms_tick = 1'b0;
    forever begin
      @(posedge clk); #1;
      div = (div == 9) ? 0 : div + 1;
      ms_tick = (div == 9);
    end
  end

  // slow-stream monitor
  bit f_prev = 0, f_has = 0, f_expect2 = 0;
  int f_acc = 0, f_last_t = 0, f_hi = 0, f_w = 0, f_low = 1000;
  always @(negedge clk) begin
    bit o, t;
    int p;
    o = f1 | f2; t = ms_tick;
    if (!rst_n) begin
      f_prev = 0; f_has = 0; f_expect2 = 0; f_acc = 0; f_last_t = 0;
      f_hi = 0; f_low = 1000;
    end else begin
      if (f1 && f2) chk(0, "R2 overlap", 1, 0);
      if (o && !f_prev) begin
        p = f_acc - f_last_t;
        f_w = exp_width(!f_has, p, FW);
        chk(f2 == f_expect2, "R2 alternation", int'(f2), int'(f_expect2));
        chk(f_low >= GAP, "R6 low gap", f_low, GAP);
        f_expect2 = ~f_expect2;
        f_has = 1; f_acc = t; f_hi = t; f_rises++;
      end else begin
        f_acc += t;
        if (o) f_hi += t;
      end
      if (!o && f_prev)
        chk(f_hi == f_w, (f_w == FW) ? "R3 nominal width" : "R5 short width", f_hi, f_w);
      f_low = o ? 0 : f_low + 1;
      f_last_t = t; f_prev = o;
    end
  end

  // calibration-stream monitor
  bit c_prev = 0, c_has = 0;
  int c_acc = 0, c_last_t = 0, c_hi = 0, c_w = 0;
  always @(negedge clk) begin
    bit t;
    int p;
    t = ms_tick;
    if (!rst_n) begin
      c_prev = 0; c_has = 0; c_acc = 0; c_last_t = 0; c_hi = 0;
    end else begin
      if (cf && !c_prev) begin
        p = c_acc - c_last_t;
        c_w = exp_width(!c_has, p, CW);
        c_has = 1; c_acc = t; c_hi = t; cf_rises++;
      end else begin
        c_acc += t;
        if (cf) c_hi += t;
      end
      if (!cf && c_prev)
        chk(c_hi == c_w, (c_w == CW) ? "R4 nominal width" : "R5 short width", c_hi, c_w);
      c_last_t = t; c_prev = cf;
    end
  end

  task automatic send_f();
    @(posedge clk); #1 f_evt = 1'b1;
    @(posedge clk); #1 f_evt = 1'b0;
    f_sent++;
  endtask

  task automatic send_cf();
    @(posedge clk); #1 cf_evt = 1'b1;
    @(posedge clk); #1 cf_evt = 1'b0;
    cf_sent++;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({f1, f2, cf, f_ovf, cf_ovf} == 5'b0, "R1 reset outputs",
        int'({f1, f2, cf, f_ovf, cf_ovf}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    int base;
    rst_n = 1'b0; f_evt = 1'b0; cf_evt = 1'b0;
    do_reset();
    repeat (5) @(posedge clk);

    // R9 and R1: start latency and first phase on F1
    @(posedge clk); #1 f_evt = 1'b1;
    @(posedge clk); #1 f_evt = 1'b0; f_sent++;
    @(negedge clk);
    chk(!(f1 || f2), "R9 not yet high", int'(f1 | f2), 0);
    @(negedge clk);
    chk(f1 && !f2, "R1 first pulse on F1", int'({f1, f2}), 2);
    @(posedge clk); #1 cf_evt = 1'b1;
    @(posedge clk); #1 cf_evt = 1'b0; cf_sent++;
    @(negedge clk);
    chk(!cf, "R9 CF not yet high", int'(cf), 0);
    @(negedge clk);
    chk(cf, "R9 CF high on second cycle", int'(cf), 1);
    repeat (300) @(posedge clk);

    // R3/R4/R5/R10: spacing sweep on both streams at once
    fork
      for (int iv = 130; iv >= 20; iv -= 7)
        for (int k = 0; k < 4; k++) begin
          send_f();
          repeat (iv - 2) @(posedge clk);
        end
      for (int iv = 90; iv >= 20; iv -= 9)
        for (int k = 0; k < 5; k++) begin
          send_cf();
          repeat (iv - 2) @(posedge clk);
        end
    join
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(f_rises == f_sent, "R10 slow pulses per strobe", f_rises, f_sent);
    chk(cf_rises == cf_sent, "R10 CF pulses per strobe", cf_rises, cf_sent);
    chk(!f_ovf && !cf_ovf, "R8 no drop when spaced", int'({f_ovf, cf_ovf}), 0);

    // R7: strobe during a busy pulse is held and delivered
    base = f_rises;
    send_f();
    repeat (18) @(posedge clk);
    send_f();
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(f_rises == base + 2, "R7 held strobe delivered", f_rises, base + 2);
    chk(!f_ovf, "R7 no overflow on single hold", int'(f_ovf), 0);

    // R8: third strobe while one is held is dropped and flagged
    base = f_rises;
    send_f();
    repeat (18) @(posedge clk);
    send_f();
    repeat (8) @(posedge clk);
    send_f();
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk(f_rises == base + 2, "R8 third strobe dropped", f_rises, base + 2);
    chk(f_ovf, "R8 slow overflow set", int'(f_ovf), 1);
    chk(!cf_ovf, "R8 CF flag untouched", int'(cf_ovf), 0);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk(f_ovf, "R8 overflow sticky", int'(f_ovf), 1);

    // CF overflow
    base = cf_rises;
    send_cf(); send_cf(); send_cf();
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(cf_ovf, "R8 CF overflow set", int'(cf_ovf), 1);
    chk(cf_rises == base + 2, "R8 CF third strobe dropped", cf_rises, base + 2);

    // R1: reset mid-run clears flags and restarts on F1
    send_f();
    repeat (5) @(posedge clk);
    do_reset();
    repeat (3) @(posedge clk);
    send_f();
    @(negedge clk);
    @(negedge clk);
    chk(f1 && !f2, "R1 restart on F1", int'({f1, f2}), 2);
    repeat (100) @(posedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule